// File: doc/BRIEF.md
# Interleaved ADC Timing Skew Estimator

This block trims the sampling-clock skew of a four-way time-interleaved converter, working from the converted data alone. In every clock cycle it takes one frame of four 12-bit samples, one from each sub-converter in interleaving order. For each pair of neighbouring sub-converters it forms the sample difference and takes its magnitude. This gives four pairs, counting the wrap from the last channel to the first channel of the following frame. Over a window of 2^N frames it sums these magnitudes. Each sum is then a measure of the real time gap between the two sampling instants of that pair.

When a window closes, each of channels 1 to 3 compares the gap in front of it with the gap after it. It moves its 6-bit delay-trim code one step toward making the two gaps equal. Channel 0 stays fixed as the timing anchor. A deadband keeps codes still when the two gaps already agree within a programmable margin. A converged flag reports that the loop has stopped moving. The codes drive the analog delay cells of each channel's sampling clock, and those cells are outside this block.

Top module: `tiadc_skew_cal`

## Requirements
- R1: `frame_i` bits [12k+11:12k] hold the unsigned sample of channel k (k = 0..3). The pair magnitudes are |ch1-ch0|, |ch2-ch1| and |ch3-ch2| from the same frame, each computed as a 13-bit signed difference.
- R2: The fourth pair magnitude is |ch0 of this frame - ch3 of the previous frame|. In the first frame after reset this term counts as zero.
- R3: A window lasts 2^N frames. N is `win_log2_i` clamped to the range 8..16. `win_done_o` is high for exactly the one cycle after the last frame of a window has been taken.
- R4: All four sums restart from zero with the first frame of every window, so each decision sees only the frames of its own window.
- R5: The code of channel 0 is always 32. Codes change only at the cycle where `win_done_o` goes high. Channel k (1..3) steps up by one when the sum of pair k exceeds the sum of pair k-1. It steps down by one when the sum of pair k-1 exceeds the sum of pair k.
- R6: A code keeps its value when the absolute difference of the two sums it compares is less than or equal to `deadband_i`.
- R7: Codes saturate at 0 and 63 and never change by more than one step per window.
- R8: `converged_o` rises at the end of a window once at least `conv_need_i` consecutive windows have ended with no code value changing. It falls at the end of any window in which a code changes. It changes at no other time.
- R9: While `rst_n` is low at a clock edge, all codes become 32 and `converged_o` and `win_done_o` clear. The sums, the window position and the wrap history are also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one frame per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_i | input | 48 | Four 12-bit samples, channel k at bits [12k+11:12k] |
| win_log2_i | input | 5 | Window length exponent, clamped to 8..16 |
| deadband_i | input | 28 | Minimum sum difference, exclusive, that moves a code |
| conv_need_i | input | 8 | Number of quiet windows needed for the converged flag |
| dly_code_o | output | 24 | Delay codes, channel k at bits [6k+5:6k] |
| win_done_o | output | 1 | One-cycle pulse at each window end |
| converged_o | output | 1 | Loop has settled |

## Verification
A constant frame with gaps of 100, 50, 50 and 200 drives channel 1 down and channel 3 up into their limits while channel 2 holds. This separates the step directions and shows saturation, and the quiet windows that follow raise the converged flag. A second constant pattern with a gap difference of exactly 12800 per window is run with the deadband at 12800 and then at 12799, which marks the edge of the deadband. Pseudo-random frames mix every comparison result and exercise the wrap history. Window exponents of 3 and 20 check the clamping at both ends.

// File: rtl/tsk_pkg.sv
package tsk_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/tsk_absdiff.sv
module tsk_absdiff #(
    parameter int W = 12
) (
    input  logic [W-1:0] early_i,
    input  logic [W-1:0] late_i,
    output logic [W-1:0] mag_o
);
    logic signed [W:0] diff;
    logic signed [W:0] pos;

    always_comb begin
        diff  = $signed({1'b0, late_i}) - $signed({1'b0, early_i});
        pos   = diff[W] ? -diff : diff;
        mag_o = pos[W-1:0];
    end
endmodule

// File: rtl/tsk_step_dec.sv
module tsk_step_dec
    import tsk_pkg::*;
#(
    parameter int ACC_W = 28
) (
    input  logic [ACC_W-1:0] before_i,
    input  logic [ACC_W-1:0] after_i,
    input  logic [ACC_W-1:0] thr_i,
    output step_e            step_o
);
    always_comb begin
        step_o = STEP_HOLD;
        if (after_i > before_i) begin
            if ((after_i - before_i) > thr_i) step_o = STEP_UP;
        end else if (before_i > after_i) begin
            if ((before_i - after_i) > thr_i) step_o = STEP_DOWN;
        end
    end
endmodule

// File: rtl/tiadc_skew_cal.sv
module tiadc_skew_cal
    import tsk_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int SMP_W    = 12,
    parameter int CODE_W   = 6,
    parameter int MIN_LOG2 = 8,
    parameter int MAX_LOG2 = 16,
    parameter int CONV_W   = 8,
    localparam int ACC_W   = SMP_W + MAX_LOG2,
    localparam int CNT_W   = MAX_LOG2,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*SMP_W-1:0]    frame_i,
    input  logic [LOG_W-1:0]        win_log2_i,
    input  logic [ACC_W-1:0]        deadband_i,
    input  logic [CONV_W-1:0]       conv_need_i,
    output logic [NCH*CODE_W-1:0]   dly_code_o,
    output logic                    win_done_o,
    output logic                    converged_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0]  acc;
        logic [CNT_W-1:0]           cnt;
        logic [SMP_W-1:0]           prev_last;
        logic                       prev_ok;
        logic [NCH-1:0][CODE_W-1:0] code;
        logic [CONV_W-1:0]          stable;
        logic                       conv;
        logic                       done;
    } st_t;

    st_t st_d, st_q;

    logic [NCH-1:0][SMP_W-1:0] smp;
    logic [NCH-1:0][SMP_W-1:0] mag;
    logic [NCH-1:0][ACC_W-1:0] sums;
    logic [SMP_W-1:0]          wrap_mag;
    step_e                     steps [NCH];
    logic [LOG_W-1:0]          n_eff;
    logic [CNT_W-1:0]          win_last;
    logic                      last;
    logic                      any_chg;

    assign smp = frame_i;

    // in-frame neighbour pairs
    for (genvar k = 0; k < NCH - 1; k++) begin : g_pair
        tsk_absdiff #(.W(SMP_W)) ad_i (
            .early_i (smp[k]),
            .late_i  (smp[k+1]),
            .mag_o   (mag[k])
        );
    end

    // wrap pair: last channel of previous frame to channel 0
    tsk_absdiff #(.W(SMP_W)) ad_wrap_i (
        .early_i (st_q.prev_last),
        .late_i  (smp[0]),
        .mag_o   (wrap_mag)
    );
    assign mag[NCH-1] = st_q.prev_ok ? wrap_mag : '0;

    for (genvar k = 0; k < NCH; k++) begin : g_sum
        assign sums[k] = st_q.acc[k] + ACC_W'(mag[k]);
    end

    assign steps[0] = STEP_HOLD;
    for (genvar k = 1; k < NCH; k++) begin : g_step
        tsk_step_dec #(.ACC_W(ACC_W)) sd_i (
            .before_i (sums[k-1]),
            .after_i  (sums[k]),
            .thr_i    (deadband_i),
            .step_o   (steps[k])
        );
    end

    always_comb begin
        if (win_log2_i < LOG_W'(MIN_LOG2))      n_eff = LOG_W'(MIN_LOG2);
        else if (win_log2_i > LOG_W'(MAX_LOG2)) n_eff = LOG_W'(MAX_LOG2);
        else                                    n_eff = win_log2_i;
        win_last = {CNT_W{1'b1}} >> (LOG_W'(MAX_LOG2) - n_eff);
        last     = (st_q.cnt >= win_last);
    end

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.prev_last = smp[NCH-1];
        st_d.prev_ok   = 1'b1;
        any_chg        = 1'b0;
        if (last) begin
            st_d.done = 1'b1;
            st_d.cnt  = '0;
            st_d.acc  = '0;
            for (int k = 1; k < NCH; k++) begin
                if (steps[k] == STEP_UP && st_q.code[k] != CODE_TOP) begin
                    st_d.code[k] = st_q.code[k] + 1'b1;
                    any_chg      = 1'b1;
                end else if (steps[k] == STEP_DOWN && st_q.code[k] != '0) begin
                    st_d.code[k] = st_q.code[k] - 1'b1;
                    any_chg      = 1'b1;
                end
            end
            if (any_chg) begin
                st_d.stable = '0;
                st_d.conv   = 1'b0;
            end else begin
                if (st_q.stable != '1) st_d.stable = st_q.stable + 1'b1;
                st_d.conv = (st_d.stable >= conv_need_i);
            end
        end else begin
            st_d.acc = sums;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int k = 0; k < NCH; k++) st_q.code[k] <= CODE_MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_code_o  = st_q.code;
    assign win_done_o  = st_q.done;
    assign converged_o = st_q.conv;
endmodule

// File: rtl/tsk_skew_chk.sv
module tsk_skew_chk #(
    parameter int NCH    = 4,
    parameter int CODE_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH*CODE_W-1:0] code_i,
    input logic                  win_done_i,
    input logic                  converged_i
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    a_r5_anchor_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        code_i[CODE_W-1:0] == MID);

    a_r5_move_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done_i |-> $stable(code_i));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_i |=> !win_done_i);

    a_r8_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done_i |-> $stable(converged_i));

    a_r8_drop_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done_i && code_i != $past(code_i)) |-> !converged_i);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            (code_i[k*CODE_W +: CODE_W] == $past(code_i[k*CODE_W +: CODE_W])) ||
            (code_i[k*CODE_W +: CODE_W] == $past(code_i[k*CODE_W +: CODE_W]) + 1'b1) ||
            (code_i[k*CODE_W +: CODE_W] == $past(code_i[k*CODE_W +: CODE_W]) - 1'b1));
    end
endmodule

bind tiadc_skew_cal tsk_skew_chk #(.NCH(NCH), .CODE_W(CODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_i      (dly_code_o),
    .win_done_i  (win_done_o),
    .converged_i (converged_o)
);

// File: tb/tiadc_skew_cal_tb_top.sv
module tiadc_skew_cal_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] frame = '0;
    logic [4:0]  win_log2 = 5'd8;
    logic [27:0] deadband = '0;
    logic [7:0]  conv_need = 8'd3;
    logic [23:0] dly_code;
    logic        win_done;
    logic        converged;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    longint m_acc [4];
    int m_cnt, m_prev3, m_code [4], m_stable, m_wins;
    bit m_prev_ok, m_conv, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiadc_skew_cal dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_i     (frame),
        .win_log2_i  (win_log2),
        .deadband_i  (deadband),
        .conv_need_i (conv_need),
        .dly_code_o  (dly_code),
        .win_done_o  (win_done),
        .converged_o (converged)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int smp(int k);
        return int'(frame[12*k +: 12]);
    endfunction

    function automatic int dut_code(int k);
        return int'(dly_code[6*k +: 6]);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_code[k] = 32; end
            m_cnt = 0; m_prev3 = 0; m_prev_ok = 0; m_stable = 0;
            m_conv = 0; m_done = 0;
        end else begin
            longint s [4];
            int n, len;
            bit moved;
            for (int k = 0; k < 3; k++) s[k] = m_acc[k] + iabs(smp(k+1) - smp(k));
            s[3] = m_acc[3] + (m_prev_ok ? iabs(smp(0) - m_prev3) : 0);
            n = int'(win_log2);
            if (n < 8) n = 8;
            if (n > 16) n = 16;
            len = 1 << n;
            m_done = 0;
            if (m_cnt >= len - 1) begin
                m_done = 1;
                m_wins++;
                moved = 0;
                for (int k = 1; k < 4; k++) begin
                    longint dlt;
                    dlt = s[k] - s[k-1];
                    if (dlt > longint'(deadband) && m_code[k] < 63) begin m_code[k]++; moved = 1; end
                    else if (-dlt > longint'(deadband) && m_code[k] > 0) begin m_code[k]--; moved = 1; end
                end
                if (moved) begin m_stable = 0; m_conv = 0; end
                else begin
                    if (m_stable < 255) m_stable++;
                    m_conv = (m_stable >= int'(conv_need));
                end
                for (int k = 0; k < 4; k++) m_acc[k] = 0;
                m_cnt = 0;
            end else begin
                for (int k = 0; k < 4; k++) m_acc[k] = s[k];
                m_cnt++;
            end
            m_prev3 = smp(3);
            m_prev_ok = 1;
        end
    end

    // cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int k = 0; k < 4; k++)
                chk(dut_code(k) == m_code[k], "R5", $sformatf("code ch%0d", k), dut_code(k), m_code[k]);
            chk(win_done == m_done, "R3", "win_done", int'(win_done), int'(m_done));
            chk(converged == m_conv, "R8", "converged", int'(converged), int'(m_conv));
        end
    end

    task automatic set_frame(int a, int b, int c, int d);
        frame = {12'(d), 12'(c), 12'(b), 12'(a)};
    endtask

    task automatic wait_windows(int n);
        int target;
        target = m_wins + n;
        while (m_wins < target) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        m_wins = 0;
        set_frame(1000, 1100, 1150, 1200);
        repeat (3) @(negedge clk);
        // R9: reset state
        for (int k = 0; k < 4; k++) chk(dut_code(k) == 32, "R9", "reset code", dut_code(k), 32);
        chk(!converged && !win_done, "R9", "reset flags", int'(converged) + int'(win_done), 0);
        rst_n = 1'b1;

        // R1 R2 R5: gaps 100,50,50,200 -> ch1 down, ch2 hold, ch3 up; R7 limits
        wait_windows(40);
        chk(dut_code(1) == 0, "R7", "ch1 floor", dut_code(1), 0);
        chk(dut_code(2) == 32, "R5", "ch2 hold", dut_code(2), 32);
        chk(dut_code(3) == 63, "R7", "ch3 ceiling", dut_code(3), 63);
        chk(converged == 1'b1, "R8", "settled", int'(converged), 1);

        // R6: gaps 50,100,50,200; ch1 difference is exactly 12800 per window
        set_frame(0, 50, 150, 200);
        deadband = 28'd12800;
        wait_windows(2);
        chk(dut_code(1) == 0, "R6", "deadband edge holds", dut_code(1), 0);
        deadband = 28'd12799;
        wait_windows(1);
        chk(dut_code(1) == 1, "R6", "just past deadband", dut_code(1), 1);
        chk(converged == 1'b0, "R8", "flag drops on move", int'(converged), 0);

        // R4 R2: pseudo-random frames
        deadband = '0;
        lfsr = 16'hACE1;
        for (int i = 0; i < 8 * 256; i++) begin
            frame[11:0]  = lfsr[11:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame[23:12] = lfsr[15:4];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame[35:24] = lfsr[11:0];
            frame[47:36] = lfsr[13:2] ^ 12'h5A5;
            @(negedge clk);
        end

        // R3: exponent clamp low and high
        set_frame(500, 700, 800, 900);
        win_log2 = 5'd3;
        wait_windows(2);
        win_log2 = 5'd20;
        wait_windows(1);
        chk(m_cnt == 0, "R3", "long window closed", m_cnt, 0);

        // R9: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) chk(dut_code(k) == 32, "R9", "re-reset code", dut_code(k), 32);
        chk(!converged, "R9", "re-reset flag", int'(converged), 0);
        summary();
    end
endmodule